// File: doc/BRIEF.md
# Dual-Input Serial Audio Frame Relay

This block takes two serial stereo audio inputs in the common I2S arrangement (bit clock, word select, data) and relays one of them to three identical serial data outputs. A select input picks which source acts as the timing master. The chosen bit clock and word select are forwarded straight to the clock outputs, so downstream devices see the source timing with no delay. The data is received word by word and sent out again exactly one stereo frame later, in the same slot position as the input.

Inputs run at an unknown word length that may change from frame to frame. Any length up to 18 bits passes through at its own width. Longer words are cut to their 18 most significant bits. The block works in a fast system clock domain and oversamples the serial lines, so the bit clock must be several system cycles per half period. The outputs carry zero samples until a complete left/right frame has arrived from the current source. This applies after reset and after every change of source. Enable outputs tell the pads when to float the forwarded clocks and the third data lane.

Top module: `i2s_frame_relay`

## Requirements
- R1: During and right after reset, every data lane is 0, the clock pad enable is 1 and the third-lane enable is 0 (with both control inputs at 0).
- R2: `bck_o` and `ws_o` combinationally follow input A when `src_sel_i` is 0 and input B when it is 1, at all times.
- R3: Word select 0 marks a left word and 1 marks a right word. The MSB of a word occupies the bit period after the word-select change. Output data changes only after a falling bit-clock edge and is stable at the next rising edge.
- R4: A word received in some slot (left or right) of frame N is sent, MSB first, in the same slot of frame N+1. Bit k of the output slot is bit k of the stored word.
- R5: A word shorter than 18 bits is sent with exactly its received length. Zeros follow it until the slot ends.
- R6: A word longer than 18 bits is sent as its first 18 received bits, followed by zeros. The stored length never exceeds 18.
- R7: All three data lanes carry the same bit in every cycle.
- R8: `clk_oe_o` is the inverse of `clk_hiz_i`, and `last_oe_o` follows `last_en_i`.
- R9: After reset or a change of `src_sel_i`, the lanes send only zeros until one complete left word, then one complete right word, have been received from the selected input. A word counts as complete only if its start (a word-select change) was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low reset |
| src_sel_i | input | 1 | Timing master select: 0 input A, 1 input B |
| clk_hiz_i | input | 1 | 1 floats the forwarded bit clock and word select |
| last_en_i | input | 1 | 1 drives the last data lane, 0 floats it |
| bck_a_i | input | 1 | Input A bit clock |
| ws_a_i | input | 1 | Input A word select |
| sd_a_i | input | 1 | Input A serial data |
| bck_b_i | input | 1 | Input B bit clock |
| ws_b_i | input | 1 | Input B word select |
| sd_b_i | input | 1 | Input B serial data |
| bck_o | output | 1 | Forwarded bit clock |
| ws_o | output | 1 | Forwarded word select |
| clk_oe_o | output | 1 | Pad enable for bck_o and ws_o |
| sd_o | output | NUM_OUT | Relayed serial data lanes |
| last_oe_o | output | 1 | Pad enable for lane NUM_OUT-1 |

## Verification
The hardest condition to create is a frame whose output slot length differs from the stored word length. Here the transmitter must either cut a long stored word to the slot, or pad a short one with zeros. The stimulus reaches this with directed frames of unequal left and right lengths, including 12, 20 and 24 bits, and then random lengths from 2 to 26 bits, so that consecutive frames rarely match. The source is also switched while the old input rests with its bit clock high and the new one low. This checks that the forwarded clock jumps at once and that the two-frame zero window restarts.

// File: rtl/relay_pkg.sv
package relay_pkg;
    // One sample of a serial audio line triple
    typedef struct packed {
        logic bck;
        logic ws;
        logic sd;
    } ser_t;
endpackage

// File: rtl/relay_front.sv
module relay_front
    import relay_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  ser_t a_i,
    input  ser_t b_i,
    output ser_t cur_o,
    output logic rise_o,
    output logic fall_o,
    output logic clr_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        ser_t [SYNC_STAGES-1:0] pa;
        ser_t [SYNC_STAGES-1:0] pb;
        logic                   sel;
        logic                   bck_prev;
    } front_t;

    front_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = LAST; i > 0; i--) begin
            st_d.pa[i] = st_q.pa[i-1];
            st_d.pb[i] = st_q.pb[i-1];
        end
        st_d.pa[0]    = a_i;
        st_d.pb[0]    = b_i;
        clr_o         = (sel_i != st_q.sel);
        cur_o         = sel_i ? st_q.pb[LAST] : st_q.pa[LAST];
        rise_o        = !clr_o &&  cur_o.bck && !st_q.bck_prev;
        fall_o        = !clr_o && !cur_o.bck &&  st_q.bck_prev;
        st_d.sel      = sel_i;
        st_d.bck_prev = cur_o.bck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/relay_rx.sv
module relay_rx #(
    parameter int W  = 18,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_i,
    input  logic          clr_i,
    input  logic          ws_i,
    input  logic          sd_i,
    output logic [W-1:0]  word_l_o,
    output logic [LW-1:0] len_l_o,
    output logic [W-1:0]  word_r_o,
    output logic [LW-1:0] len_r_o
);
    typedef struct packed {
        logic [W-1:0]  sh;
        logic [LW-1:0] cnt;
        logic          ws_last;
        logic          wsv;
        logic          started;
        logic          lvalid;
        logic [W-1:0]  hold;
        logic [LW-1:0] hold_len;
        logic [W-1:0]  bl;
        logic [LW-1:0] ll;
        logic [W-1:0]  br;
        logic [LW-1:0] lr;
    } rx_t;

    rx_t st_q, st_d;

    always_comb begin
        logic [W-1:0]  word;
        logic [LW-1:0] len;
        logic [LW-1:0] pos;
        st_d = st_q;
        word = st_q.sh;
        len  = st_q.cnt;
        pos  = LW'(W - 1) - st_q.cnt;
        if (st_q.cnt < LW'(W)) begin
            word[pos] = sd_i;
            len       = st_q.cnt + 1'b1;
        end
        if (clr_i) begin
            st_d = '0;
        end else if (rise_i) begin
            st_d.sh  = word;
            st_d.cnt = len;
            if (!st_q.wsv) begin
                st_d.wsv     = 1'b1;
                st_d.ws_last = ws_i;
            end else if (ws_i != st_q.ws_last) begin
                st_d.sh      = '0;
                st_d.cnt     = '0;
                st_d.ws_last = ws_i;
                st_d.started = 1'b1;
                if (st_q.started) begin
                    if (!st_q.ws_last) begin
                        st_d.hold     = word;
                        st_d.hold_len = len;
                        st_d.lvalid   = 1'b1;
                    end else if (st_q.lvalid) begin
                        st_d.bl     = st_q.hold;
                        st_d.ll     = st_q.hold_len;
                        st_d.br     = word;
                        st_d.lr     = len;
                        st_d.lvalid = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_l_o = st_q.bl;
    assign len_l_o  = st_q.ll;
    assign word_r_o = st_q.br;
    assign len_r_o  = st_q.lr;
endmodule

// File: rtl/relay_tx.sv
module relay_tx #(
    parameter int W  = 18,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    input  logic          clr_i,
    input  logic          ws_i,
    input  logic [W-1:0]  word_l_i,
    input  logic [LW-1:0] len_l_i,
    input  logic [W-1:0]  word_r_i,
    input  logic [LW-1:0] len_r_i,
    output logic          sd_o
);
    typedef struct packed {
        logic          wsf;
        logic          wsfv;
        logic [LW-1:0] idx;
        logic          sd;
    } tx_t;

    localparam tx_t IDLE = '{wsf: 1'b0, wsfv: 1'b0, idx: LW'(W), sd: 1'b0};

    tx_t st_q, st_d;

    always_comb begin
        logic [W-1:0]  word;
        logic [LW-1:0] len;
        logic [LW-1:0] pos;
        st_d = st_q;
        word = st_q.wsf ? word_r_i : word_l_i;
        len  = st_q.wsf ? len_r_i  : len_l_i;
        pos  = LW'(W - 1) - st_q.idx;
        if (clr_i) begin
            st_d = IDLE;
        end else if (fall_i) begin
            st_d.wsf = ws_i;
            if (!st_q.wsfv) begin
                st_d.wsfv = 1'b1;
                st_d.sd   = 1'b0;
                st_d.idx  = LW'(W);
            end else begin
                st_d.sd = (st_q.idx < len) ? word[pos] : 1'b0;
                if (ws_i != st_q.wsf)        st_d.idx = '0;
                else if (st_q.idx < LW'(W))  st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE;
        else        st_q <= st_d;
    end

    assign sd_o = st_q.sd;
endmodule

// File: rtl/i2s_frame_relay.sv
module i2s_frame_relay
    import relay_pkg::*;
#(
    parameter int WORD_W      = 18,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_OUT     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_sel_i,
    input  logic               clk_hiz_i,
    input  logic               last_en_i,
    input  logic               bck_a_i,
    input  logic               ws_a_i,
    input  logic               sd_a_i,
    input  logic               bck_b_i,
    input  logic               ws_b_i,
    input  logic               sd_b_i,
    output logic               bck_o,
    output logic               ws_o,
    output logic               clk_oe_o,
    output logic [NUM_OUT-1:0] sd_o,
    output logic               last_oe_o
);
    localparam int LEN_W = $clog2(WORD_W + 1);

    ser_t              cur;
    logic              edge_rise, edge_fall, sel_clr, tx_bit;
    logic [WORD_W-1:0] buf_l, buf_r;
    logic [LEN_W-1:0]  len_l, len_r;

    relay_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .sel_i(src_sel_i),
        .a_i('{bck: bck_a_i, ws: ws_a_i, sd: sd_a_i}),
        .b_i('{bck: bck_b_i, ws: ws_b_i, sd: sd_b_i}),
        .cur_o(cur), .rise_o(edge_rise), .fall_o(edge_fall), .clr_o(sel_clr)
    );

    relay_rx #(.W(WORD_W), .LW(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise_i(edge_rise), .clr_i(sel_clr),
        .ws_i(cur.ws), .sd_i(cur.sd),
        .word_l_o(buf_l), .len_l_o(len_l), .word_r_o(buf_r), .len_r_o(len_r)
    );

    relay_tx #(.W(WORD_W), .LW(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .fall_i(edge_fall), .clr_i(sel_clr),
        .ws_i(cur.ws), .word_l_i(buf_l), .len_l_i(len_l),
        .word_r_i(buf_r), .len_r_i(len_r), .sd_o(tx_bit)
    );

    // Clocks forwarded without registers to stay in phase with the source
    assign bck_o     = src_sel_i ? bck_b_i : bck_a_i;
    assign ws_o      = src_sel_i ? ws_b_i  : ws_a_i;
    assign clk_oe_o  = !clk_hiz_i;
    assign last_oe_o = last_en_i;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        assign sd_o[g] = tx_bit;
    end
endmodule

// File: rtl/relay_chk.sv
module relay_chk #(
    parameter int W  = 18,
    parameter int LW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rise,
    input logic          fall,
    input logic          clr,
    input logic          ws,
    input logic          sd,
    input logic [W-1:0]  buf_l,
    input logic [W-1:0]  buf_r,
    input logic [LW-1:0] len_l,
    input logic [LW-1:0] len_r
);
    AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sd != $past(sd)) |-> ($past(fall) || $past(clr))); // R3

    AST_BUF_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_l != $past(buf_l)) || (buf_r != $past(buf_r))) |-> ($past(rise) || $past(clr))); // R4

    AST_LOAD_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_r != $past(buf_r)) && !$past(clr)) |-> !$past(ws)); // R4

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (len_l <= LW'(W)) && (len_r <= LW'(W))); // R6

    AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((buf_l == '0) && (buf_r == '0) && !sd)); // R9
endmodule

bind i2s_frame_relay relay_chk #(.W(WORD_W), .LW(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rise(edge_rise), .fall(edge_fall), .clr(sel_clr),
    .ws(cur.ws), .sd(tx_bit), .buf_l(buf_l), .buf_r(buf_r), .len_l(len_l), .len_r(len_r)
);

// File: tb/tb_i2s_frame_relay.sv
module tb_i2s_frame_relay;
    localparam int W = 18;
    localparam int H = 8;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, hiz = 1'b0, len3 = 1'b0;
    logic bck_a = 1'b0, ws_a = 1'b0, sd_a = 1'b0;
    logic bck_b = 1'b0, ws_b = 1'b0, sd_b = 1'b0;
    logic bck_o, ws_o, clk_oe, last_oe;
    logic [N-1:0] sd_o;

    int checks = 0, errors = 0, frames_seen = 0;
    int prev_ll = 0, prev_rl = 0;
    logic [31:0] prev_lv = '0, prev_rv = '0;
    bit done = 0;

    always #10 clk = ~clk;

    i2s_frame_relay dut (
        .clk(clk), .rst_n(rst_n), .src_sel_i(sel), .clk_hiz_i(hiz), .last_en_i(len3),
        .bck_a_i(bck_a), .ws_a_i(ws_a), .sd_a_i(sd_a),
        .bck_b_i(bck_b), .ws_b_i(ws_b), .sd_b_i(sd_b),
        .bck_o(bck_o), .ws_o(ws_o), .clk_oe_o(clk_oe), .sd_o(sd_o), .last_oe_o(last_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected output slot from the requirements: stored word cut to 18, padded with zeros
    function automatic logic [31:0] exp_slot(bit valid, int plen, logic [31:0] pval, int slen);
        logic [31:0] r = '0;
        for (int j = 0; j < slen; j++) begin
            logic b;
            b = (valid && j < plen && j < W) ? pval[plen-1-j] : 1'b0;
            r = {r[30:0], b};
        end
        return r;
    endfunction

    task automatic set_line(input bit port, input logic bk, input logic w, input logic d);
        if (port) begin bck_b = bk; ws_b = w; sd_b = d; end
        else      begin bck_a = bk; ws_a = w; sd_a = d; end
    endtask

    task automatic drive_bit(input bit port, input logic w, input logic d,
                             output logic got, inout int fwd_bad, inout int lane_bad);
        @(negedge clk);
        set_line(port, 1'b0, w, d);
        repeat (H) @(negedge clk);
        if (bck_o !== 1'b0 || ws_o !== w) fwd_bad++;
        if (sd_o[0] !== sd_o[1] || sd_o[1] !== sd_o[2]) lane_bad++;
        got = sd_o[0];
        set_line(port, 1'b1, w, d);
        repeat (H) @(negedge clk);
        if (bck_o !== 1'b1 || ws_o !== w) fwd_bad++;
        if (sd_o[0] !== got) lane_bad++;   // data held over the rising edge (R3)
    endtask

    task automatic send_frame(input bit port, input int lw, input logic [31:0] lv,
                              input int rw, input logic [31:0] rv);
        logic [31:0] gl = '0, gr = '0, el, er;
        logic g;
        int fb = 0, lb = 0;
        bit valid;
        string tag;
        for (int j = 0; j < lw; j++) begin
            drive_bit(port, (j == lw - 1), lv[lw-1-j], g, fb, lb);
            gl = {gl[30:0], g};
        end
        for (int j = 0; j < rw; j++) begin
            drive_bit(port, (j != rw - 1), rv[rw-1-j], g, fb, lb);
            gr = {gr[30:0], g};
        end
        valid = (frames_seen >= 2);
        el = exp_slot(valid, prev_ll, prev_lv, lw);
        er = exp_slot(valid, prev_rl, prev_rv, rw);
        tag = !valid ? "R9 zero window" : (prev_ll > W) ? "R6 long word" :
              (prev_ll < W) ? "R5 short word" : "R4 one-frame delay";
        check(gl === el, {tag, " left slot"}, gl, el);
        tag = !valid ? "R9 zero window" : (prev_rl > W) ? "R6 long word" :
              (prev_rl < W) ? "R5 short word" : "R4 one-frame delay";
        check(gr === er, {tag, " right slot"}, gr, er);
        check(lb == 0, "R7 lanes equal / R3 hold at rise", lb, 0);
        check(fb == 0, "R2 clock forwarding", fb, 0);
        prev_ll = lw; prev_lv = lv; prev_rl = rw; prev_rv = rv;
        frames_seen++;
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        // R1: reset state
        check(sd_o === '0, "R1 lanes zero in reset", sd_o, 0);
        check(clk_oe === 1'b1 && last_oe === 1'b0, "R1 enables in reset", {clk_oe, last_oe}, 2'b10);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sd_o === '0, "R1 lanes zero after reset", sd_o, 0);

        // Directed frames on input A
        send_frame(0, 18, 32'h2A5C3, 18, 32'h1F00F);
        send_frame(0, 18, 32'h3FFFF, 18, 32'h20001);
        send_frame(0, 16, 32'hBEEF, 16, 32'h8001);
        send_frame(0, 24, 32'hA5F0C3, 24, 32'h7E1234);
        send_frame(0, 12, 32'hABC, 20, 32'hFACE1);
        send_frame(0, 20, 32'h9ACE5, 12, 32'h5A5);
        send_frame(0, 18, 32'h15555, 18, 32'h2AAAA);
        // Random lengths and data
        for (int k = 0; k < 16; k++) begin
            int lw, rw;
            lw = 2 + int'($urandom % 25);
            rw = 2 + int'($urandom % 25);
            send_frame(0, lw, $urandom, rw, $urandom);
        end

        // R8: pad enables
        @(negedge clk); hiz = 1'b1; len3 = 1'b1;
        @(negedge clk);
        check(clk_oe === 1'b0, "R8 clock pads floated", clk_oe, 0);
        check(last_oe === 1'b1, "R8 last lane driven", last_oe, 1);
        hiz = 1'b0; len3 = 1'b0;
        @(negedge clk);
        check(clk_oe === 1'b1 && last_oe === 1'b0, "R8 enables restored", {clk_oe, last_oe}, 2'b10);

        // R2 / R9: switch to input B (A rests with bit clock high, B low)
        sel = 1'b1;
        @(negedge clk);
        check(bck_o === bck_b && bck_o !== bck_a, "R2 select input B", bck_o, bck_b);
        repeat (6) @(negedge clk);
        check(sd_o === '0, "R9 lanes cleared on switch", sd_o, 0);
        frames_seen = 0;
        send_frame(1, 18, 32'h12345, 18, 32'h3CAFE);
        send_frame(1, 14, 32'h2D2D, 22, 32'h3ABCDE);
        send_frame(1, 18, 32'h00001, 18, 32'h20000);
        for (int k = 0; k < 6; k++) begin
            int lw, rw;
            lw = 2 + int'($urandom % 25);
            rw = 2 + int'($urandom % 25);
            send_frame(1, lw, $urandom, rw, $urandom);
        end

        // Back to input A: zero window restarts (R9)
        sel = 1'b0;
        @(negedge clk);
        check(bck_o === bck_a, "R2 select input A", bck_o, bck_a);
        repeat (6) @(negedge clk);
        frames_seen = 0;
        send_frame(0, 18, 32'h0F0F0, 18, 32'h30303);
        send_frame(0, 17, 32'h1AAAA, 19, 32'h55555);
        send_frame(0, 18, 32'h11111, 18, 32'h22222);

        done = 1;
        finish_up();
    end
endmodule